// File: doc/BRIEF.md
# Hololine Scan Sync Adapter

This block adapts the timing of a graphics-style video source to a scanning holographic display. The source spreads one display hololine over many short framebuffer lines and issues a one-cycle horizontal strobe at the end of each framebuffer line. The source also issues a one-cycle vertical strobe at the end of each frame. The adapter counts the horizontal strobes and emits one hololine strobe for every 178 of them. The display uses that strobe to restart its horizontal mirror sweep.

For each hololine, the adapter also produces two drive values. The first is a direction bit that alternates the sweep between left-to-right and right-to-left, so that the return sweep also carries image data. The second is a small step code for an external DAC, which drives the vertical mirror. The code forms a staircase that rises one level per hololine. Eight levels make a frame, and each level corresponds to a band of 18 display lines that parallel modulator channels write at the same time. After the eight active hololines, the vertical mirror retraces during two further hololine periods. The next vertical strobe then starts a new frame with a forward sweep and step zero. If more hololines arrive than a frame can hold, the step code stays at its top level and an error flag is set.

All inputs are synchronous one-cycle strobes in the block clock domain. The only data leaving the block is a code with a qualifier. The display samples this code and cannot stall, so the block has no ready input and no back-pressure. Every other pin is plain control.

Top module: `hololine_sync_adapter`

## Requirements
- R1: While reset is held, and after its release until the first strobe, `holo_sync_o`, `dir_rev_o`, `vstep_o`, `vstep_valid_o` and `overrun_o` are all 0.
- R2: `holo_sync_o` is a single-cycle pulse. It is asserted in the cycle after every 178th `hsync_i` counted since the last `vsync_i` or reset, and at no other time.
- R3: `vsync_i` clears the framebuffer-line count. An `hsync_i` in the same cycle as `vsync_i` is not counted, and `vsync_i` takes priority over any hololine strobe that is in flight.
- R4: `dir_rev_o` encodes the sweep direction (0 = forward, 1 = reverse). It is 0 in the cycle after `vsync_i`, and it inverts in the cycle after each `holo_sync_o` pulse.
- R5: `vstep_o` (3 bits with default parameters) is 0 in the cycle after `vsync_i`. It rises by one in the cycle after each `holo_sync_o` pulse, saturates at 7, and otherwise holds its value.
- R6: `vstep_valid_o` is 1 only after a `vsync_i` has been seen, and only while fewer than 8 hololine pulses have occurred since that `vsync_i`. It is therefore 0 before the first frame and during the two retrace hololines.
- R7: Once a `vsync_i` has been seen, an 11th hololine pulse in one frame sets `overrun_o` in the following cycle. This is one more than the 8 active plus 2 retrace hololines. The flag stays set until the next `vsync_i`.
- R8: In the cycle after `vsync_i`, `overrun_o` is 0 and `vstep_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | One-cycle strobe at the end of each framebuffer line |
| vsync_i | input | 1 | One-cycle strobe at the end of each frame |
| holo_sync_o | output | 1 | One-cycle strobe at the end of each hololine |
| dir_rev_o | output | 1 | Sweep direction: 0 forward, 1 reverse |
| vstep_o | output | STEP_W (3) | Vertical staircase code for the DAC |
| vstep_valid_o | output | 1 | Qualifies `vstep_o` during active hololines |
| overrun_o | output | 1 | Sticky flag: too many hololines in one frame |

## Verification
The bench targets the line-count boundary. A divider that is off by one would pulse after 177 or 179 strobes, and the scoreboard would flag the pulse as early or would find a pulse missing. It restarts a half-finished hololine with a vertical strobe that arrives together with a horizontal strobe. A design that counts that strobe, or that keeps the stale count, fires too early. It runs frames past the active and retrace hololines, where a missing saturation wraps the step code back to zero and a missing overrun rule leaves the flag low. It also checks the state before the first vertical strobe, which exposes a qualifier that is asserted too soon.

// File: rtl/holo_sync_pkg.sv
package holo_sync_pkg;
  // Default timing of one display frame
  localparam int unsigned LINES_PER_HOLO_DEF = 178;
  localparam int unsigned ACTIVE_HOLOS_DEF   = 8;
  localparam int unsigned RETRACE_HOLOS_DEF  = 2;

  typedef enum logic {
    SWEEP_FWD = 1'b0,
    SWEEP_REV = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/holo_line_divider.sv
module holo_line_divider #(
  parameter int unsigned LINES = 178
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_i,
  input  logic vs_i,
  output logic tick_o
);
  localparam int unsigned CW = (LINES < 2) ? 1 : $clog2(LINES);
  localparam logic [CW-1:0] LAST = CW'(LINES - 1);

  logic [CW-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (vs_i) begin
        line_q <= '0;
      end else if (hs_i) begin
        if (line_q == LAST) begin
          line_q <= '0;
          tick_o <= 1'b1;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/holo_frame_seq.sv
module holo_frame_seq
  import holo_sync_pkg::*;
#(
  parameter int unsigned ACTIVE  = 8,
  parameter int unsigned RETRACE = 2,
  localparam int unsigned STEP_W = (ACTIVE < 2) ? 1 : $clog2(ACTIVE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              vs_i,
  output logic              dir_o,
  output logic [STEP_W-1:0] step_o,
  output logic              valid_o,
  output logic              over_o
);
  localparam int unsigned TOTAL = ACTIVE + RETRACE;
  localparam int unsigned IW    = $clog2(TOTAL + 1);
  localparam logic [IW-1:0] IDX_TOP = IW'(TOTAL);
  localparam logic [IW-1:0] IDX_ACT = IW'(ACTIVE);

  logic [IW-1:0] idx_q;
  sweep_dir_e    dir_q;
  logic          locked_q;
  logic          over_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      dir_q    <= SWEEP_FWD;
      locked_q <= 1'b0;
      over_q   <= 1'b0;
    end else if (vs_i) begin
      idx_q    <= '0;
      dir_q    <= SWEEP_FWD;
      locked_q <= 1'b1;
      over_q   <= 1'b0;
    end else if (tick_i) begin
      dir_q <= (dir_q == SWEEP_FWD) ? SWEEP_REV : SWEEP_FWD;
      if (idx_q == IDX_TOP) begin
        over_q <= over_q | locked_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (idx_q >= IDX_ACT) step_o = STEP_W'(ACTIVE - 1);
    else                  step_o = idx_q[STEP_W-1:0];
  end

  assign dir_o   = (dir_q == SWEEP_REV);
  assign valid_o = locked_q && (idx_q < IDX_ACT);
  assign over_o  = over_q;
endmodule

// File: rtl/hololine_sync_adapter.sv
module hololine_sync_adapter
  import holo_sync_pkg::*;
#(
  parameter int unsigned LINES_PER_HOLO = LINES_PER_HOLO_DEF,
  parameter int unsigned ACTIVE_HOLOS   = ACTIVE_HOLOS_DEF,
  parameter int unsigned RETRACE_HOLOS  = RETRACE_HOLOS_DEF,
  localparam int unsigned STEP_W = (ACTIVE_HOLOS < 2) ? 1 : $clog2(ACTIVE_HOLOS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_i,
  input  logic              vsync_i,
  output logic              holo_sync_o,
  output logic              dir_rev_o,
  output logic [STEP_W-1:0] vstep_o,
  output logic              vstep_valid_o,
  output logic              overrun_o
);
  logic holo_tick;

  holo_line_divider #(
    .LINES (LINES_PER_HOLO)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_i   (hsync_i),
    .vs_i   (vsync_i),
    .tick_o (holo_tick)
  );

  holo_frame_seq #(
    .ACTIVE  (ACTIVE_HOLOS),
    .RETRACE (RETRACE_HOLOS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (holo_tick),
    .vs_i    (vsync_i),
    .dir_o   (dir_rev_o),
    .step_o  (vstep_o),
    .valid_o (vstep_valid_o),
    .over_o  (overrun_o)
  );

  assign holo_sync_o = holo_tick;
endmodule

// File: rtl/hololine_sync_adapter_chk.sv
module hololine_sync_adapter_chk #(
  parameter int unsigned ACTIVE_HOLOS = 8,
  parameter int unsigned STEP_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic              holo_sync_o,
  input logic              dir_rev_o,
  input logic [STEP_W-1:0] vstep_o,
  input logic              vstep_valid_o,
  input logic              overrun_o
);
  localparam logic [STEP_W-1:0] TOP = STEP_W'(ACTIVE_HOLOS - 1);

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    holo_sync_o |=> !holo_sync_o); // R2
  AST_SYNC_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    holo_sync_o |-> $past(hsync_i && !vsync_i)); // R3
  AST_DIR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (holo_sync_o && !vsync_i) |=> (dir_rev_o != $past(dir_rev_o))); // R4
  AST_STEP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (holo_sync_o && !vsync_i && vstep_o != TOP) |=> (vstep_o == $past(vstep_o) + 1'b1)); // R5
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!holo_sync_o && !vsync_i) |=> $stable(vstep_o)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !vsync_i) |=> overrun_o); // R7
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (vstep_o == '0 && !dir_rev_o && !overrun_o && vstep_valid_o)); // R8
endmodule

bind hololine_sync_adapter hololine_sync_adapter_chk #(
  .ACTIVE_HOLOS (ACTIVE_HOLOS),
  .STEP_W       (STEP_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hsync_i       (hsync_i),
  .vsync_i       (vsync_i),
  .holo_sync_o   (holo_sync_o),
  .dir_rev_o     (dir_rev_o),
  .vstep_o       (vstep_o),
  .vstep_valid_o (vstep_valid_o),
  .overrun_o     (overrun_o)
);

// File: tb/test_hololine_sync_adapter.sv
`timescale 1ns/1ps
module test_hololine_sync_adapter;
  localparam int LINES   = 178;
  localparam int ACTIVE  = 8;
  localparam int RETRACE = 2;
  localparam int TOTAL   = ACTIVE + RETRACE;

  typedef struct {
    logic       dir;
    logic [2:0] step;
    logic       valid;
    logic       over;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_i = 1'b0;
  logic vsync_i = 1'b0;
  logic holo_sync_o, dir_rev_o, vstep_valid_o, overrun_o;
  logic [2:0] vstep_o;

  always #2.5 clk = ~clk;

  hololine_sync_adapter i_hololine_sync_adapter (
    .clk (clk), .rst_n (rst_n), .hsync_i (hsync_i), .vsync_i (vsync_i),
    .holo_sync_o (holo_sync_o), .dir_rev_o (dir_rev_o), .vstep_o (vstep_o),
    .vstep_valid_o (vstep_valid_o), .overrun_o (overrun_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_pulse = 0;
  int n_pulse_exp = 0;
  bit done = 1'b0;
  exp_t sb[$];

  // reference model state
  int  m_line = 0;
  int  m_holo = 0;
  bit  m_dir = 0;
  bit  m_lock = 0;
  bit  m_over = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: one framebuffer line, with expected item on hololine completion
  task automatic send_h();
    exp_t e;
    @(negedge clk) hsync_i = 1'b1;
    m_line++;
    if (m_line == LINES) begin
      m_line = 0;
      m_dir = ~m_dir;
      if (m_holo == TOTAL) m_over = m_over | m_lock;
      else m_holo++;
      e.dir = m_dir;
      e.step = 3'((m_holo >= ACTIVE) ? ACTIVE - 1 : m_holo);
      e.valid = m_lock && (m_holo < ACTIVE);
      e.over = m_over;
      sb.push_back(e);
      n_pulse_exp++;
    end
    @(negedge clk) hsync_i = 1'b0;
  endtask

  task automatic send_lines(int n);
    for (int i = 0; i < n; i++) send_h();
  endtask

  task automatic send_v(bit with_h);
    repeat (2) @(negedge clk);
    vsync_i = 1'b1;
    hsync_i = with_h;
    m_line = 0; m_holo = 0; m_dir = 0; m_lock = 1; m_over = 0;
    @(negedge clk);
    vsync_i = 1'b0;
    hsync_i = 1'b0;
    // R8 / R4 / R5: state in the cycle after the vertical strobe
    chk("R8 valid after vsync", vstep_valid_o, 1);
    chk("R8 overrun cleared", overrun_o, 0);
    chk("R4 dir forward after vsync", dir_rev_o, 0);
    chk("R5 step zero after vsync", vstep_o, 0);
  endtask

  // monitor: pop and compare one item per hololine pulse
  initial begin
    forever begin
      @(negedge clk);
      if (holo_sync_o) begin
        exp_t e;
        n_pulse++;
        @(negedge clk);
        chk("R2 single-cycle pulse", holo_sync_o, 0);
        if (sb.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 unexpected hololine pulse: actual 1 expected 0");
        end else begin
          e = sb.pop_front();
          chk("R4 direction", dir_rev_o, e.dir);
          chk("R5 step code", vstep_o, e.step);
          chk("R6 step valid", vstep_valid_o, e.valid);
          chk("R7 overrun", overrun_o, e.over);
        end
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 sync in reset", holo_sync_o, 0);
    chk("R1 dir in reset", dir_rev_o, 0);
    chk("R1 step in reset", vstep_o, 0);
    chk("R1 valid in reset", vstep_valid_o, 0);
    chk("R1 overrun in reset", overrun_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid idle after reset", vstep_valid_o, 0);

    // R6: before the first frame the code is not qualified
    send_lines(LINES);
    repeat (3) @(negedge clk);
    chk("R6 no valid before first vsync", vstep_valid_o, 0);

    // full frame: active, retrace, then two extra hololines (R5, R6, R7)
    send_v(1'b0);
    send_lines(LINES * (TOTAL + 2));
    repeat (3) @(negedge clk);
    chk("R7 overrun sticky", overrun_o, 1);
    chk("R5 step saturated", vstep_o, ACTIVE - 1);

    // R8: new frame clears the flag
    send_v(1'b0);
    send_lines(LINES * 3);

    // R3: partial hololine discarded, coincident hsync not counted
    send_lines(100);
    send_v(1'b1);
    send_lines(LINES - 1);
    repeat (3) @(negedge clk);
    chk("R3 no pulse after 177 lines", n_pulse, n_pulse_exp);
    send_lines(1);
    repeat (3) @(negedge clk);
    chk("R3 pulse on 178th line", n_pulse, n_pulse_exp);
    chk("R5 step after restart", vstep_o, 1);

    // normal frame sequence to confirm the staircase over a full frame
    send_v(1'b0);
    send_lines(LINES * TOTAL);
    repeat (3) @(negedge clk);
    chk("R7 no overrun at exact frame length", overrun_o, 0);
    chk("R6 valid low in retrace", vstep_valid_o, 0);
    chk("R2 pulse count", n_pulse, n_pulse_exp);
    chk("R2 scoreboard drained", sb.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule